// File: doc/BRIEF.md
# Access-Sequence Cleared Event Flags

This block keeps the event status bits of a two-wire serial bus controller working as a master receiver. The protocol engines mark events with one-cycle set pulses. Software never writes these bits to clear them. Instead, the block watches the read and write strobes of a simple register bus and clears each bit when a particular access pattern is seen.

There are five flags. Four of them use a two-step pattern. The first step is always a read of the primary status register, taken while the flag is set. The second step depends on the flag. The receive-data flag is simpler: any read of the data register clears it. A pending first step is held for each flag separately. It is dropped by any bus access that is not that flag's second step.

The block drives two interrupt outputs. The event interrupt covers the four protocol events. The buffer interrupt covers received data.

Top module: `evt_status_flags`

## Requirements
- R1: The start-sent flag (`flagStart`) clears after a read of the primary status register (address 7) followed by a write to the data register (address 6).
- R2: The address-done flag (`flagAddr`) clears after a read of address 7 followed by a read of the secondary status register (address 9).
- R3: The long-address-header flag (`flagHdr10`) clears after a read of address 7 followed by a write to address 6.
- R4: The receive-data flag (`flagRxFull`) clears on any read of address 6. No earlier status read is needed.
- R5: The transfer-finished flag (`flagXferDone`) clears after a read of address 7 followed by a read of address 6.
- R6: A read of address 7 arms only the flags that are set in that cycle. A second step with no armed first step leaves the flag set.
- R7: Any bus access between the two steps, other than a fresh read of address 7, cancels the armed step. Cycles with no access keep it.
- R8: When a set pulse and a clearing access for the same flag land in the same cycle, the flag stays set.
- R9: `evtIrq` is high exactly when `evtIrqEn` is high and at least one of start-sent, address-done, long-header or transfer-finished is set.
- R10: `bufIrq` is high exactly when `evtIrqEn`, `bufIrqEn` and the receive-data flag are all high.
- R11: After reset, all flags and both interrupts are low.
- R12: Each flag updates on the clock edge that ends the access cycle or set cycle, so it is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setStart | input | 1 | Set pulse, start condition sent |
| setAddr | input | 1 | Set pulse, address phase done |
| setHdr10 | input | 1 | Set pulse, long-address header sent |
| setRxFull | input | 1 | Set pulse, received byte available |
| setXferDone | input | 1 | Set pulse, byte transfer finished |
| busRd | input | 1 | Register read strobe |
| busWr | input | 1 | Register write strobe (never high together with busRd) |
| busAddr | input | ADDR_W | Register address |
| evtIrqEn | input | 1 | Event interrupt enable |
| bufIrqEn | input | 1 | Buffer interrupt enable |
| flagStart | output | 1 | Start-sent flag |
| flagAddr | output | 1 | Address-done flag |
| flagHdr10 | output | 1 | Long-header-sent flag |
| flagRxFull | output | 1 | Receive-data flag |
| flagXferDone | output | 1 | Transfer-finished flag |
| evtIrq | output | 1 | Event interrupt |
| bufIrq | output | 1 | Buffer interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- A flag only falls in the cycle after its own second-step access.
- An armed step always belongs to a set flag.
- Any other access drops the armed step.
- A set pulse always wins.
- Both interrupts stay low while the event enable is low.

The bench scenarios are needed to show that a complete two-step pattern really does clear a flag. They also show that idle cycles between the steps keep the armed step, and that a status read taken before the flag is set does not count.

// File: rtl/evt_flags_pkg.sv
package evt_flags_pkg;
  localparam int NFLAG  = 5;
  localparam int F_START = 0;
  localparam int F_ADDR  = 1;
  localparam int F_HDR   = 2;
  localparam int F_RX    = 3;
  localparam int F_XFER  = 4;

  typedef enum logic [1:0] {
    STEP_NONE,
    STEP_DATA_WR,
    STEP_DATA_RD,
    STEP_STS3_RD
  } step_e;

  // Second access that completes the clear sequence of each flag.
  function automatic step_e secondStep(input int idx);
    case (idx)
      F_START: return STEP_DATA_WR;
      F_ADDR:  return STEP_STS3_RD;
      F_HDR:   return STEP_DATA_WR;
      F_XFER:  return STEP_DATA_RD;
      default: return STEP_NONE;
    endcase
  endfunction

  typedef struct packed {
    logic [NFLAG-1:0] clr;
  } flagCtl_t;
endpackage

// File: rtl/evt_flags_ctrl.sv
module evt_flags_ctrl
  import evt_flags_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h6,
  parameter logic [ADDR_W-1:0] STS1_ADDR = 'h7,
  parameter logic [ADDR_W-1:0] STS3_ADDR = 'h9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NFLAG-1:0]  flags,
  output flagCtl_t          ctl
);
  logic access, sts1Rd, sts3Rd, dataRd, dataWr;
  logic [NFLAG-1:0] clrVec;

  assign access = busRd | busWr;
  assign sts1Rd = busRd && (busAddr == STS1_ADDR);
  assign sts3Rd = busRd && (busAddr == STS3_ADDR);
  assign dataRd = busRd && (busAddr == DATA_ADDR);
  assign dataWr = busWr && (busAddr == DATA_ADDR);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam step_e KIND = secondStep(i);
    if (KIND == STEP_NONE) begin : g_direct
      assign clrVec[i] = dataRd;
    end else begin : g_seq
      logic armed;
      logic hit;
      assign hit = (KIND == STEP_DATA_WR) ? dataWr :
                   (KIND == STEP_DATA_RD) ? dataRd : sts3Rd;
      always_ff @(posedge clk) begin
        if (!rstN)       armed <= 1'b0;
        else if (access) armed <= sts1Rd & flags[i];
      end
      assign clrVec[i] = armed & hit;

      AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
        armed |-> flags[i]); // R6
      AST_ARM_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
        (access && !sts1Rd) |=> !armed); // R7
    end
  end

  assign ctl.clr = clrVec;
endmodule

// File: rtl/evt_flags_dp.sv
module evt_flags_dp
  import evt_flags_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NFLAG-1:0] setVec,
  input  flagCtl_t         ctl,
  input  logic             evtIrqEn,
  input  logic             bufIrqEn,
  output logic [NFLAG-1:0] flags,
  output logic             evtIrq,
  output logic             bufIrq
);
  localparam logic [NFLAG-1:0] EVT_MASK = ~(NFLAG'(1) << F_RX);

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= setVec | (flags & ~ctl.clr);
  end

  assign evtIrq = evtIrqEn & (|(flags & EVT_MASK));
  assign bufIrq = evtIrqEn & bufIrqEn & flags[F_RX];

  for (genvar i = 0; i < NFLAG; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> flags[i]); // R8
  end

  AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !evtIrqEn |-> (!evtIrq && !bufIrq)); // R9
  AST_BUF_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    bufIrq |-> flags[F_RX]); // R10
endmodule

// File: rtl/evt_status_flags.sv
module evt_status_flags
  import evt_flags_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h6,
  parameter logic [ADDR_W-1:0] STS1_ADDR = 'h7,
  parameter logic [ADDR_W-1:0] STS3_ADDR = 'h9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setStart,
  input  logic              setAddr,
  input  logic              setHdr10,
  input  logic              setRxFull,
  input  logic              setXferDone,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              evtIrqEn,
  input  logic              bufIrqEn,
  output logic              flagStart,
  output logic              flagAddr,
  output logic              flagHdr10,
  output logic              flagRxFull,
  output logic              flagXferDone,
  output logic              evtIrq,
  output logic              bufIrq
);
  logic [NFLAG-1:0] setVec, flags;
  flagCtl_t ctl;

  assign setVec[F_START] = setStart;
  assign setVec[F_ADDR]  = setAddr;
  assign setVec[F_HDR]   = setHdr10;
  assign setVec[F_RX]    = setRxFull;
  assign setVec[F_XFER]  = setXferDone;

  evt_flags_ctrl #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR),
    .STS1_ADDR(STS1_ADDR), .STS3_ADDR(STS3_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .flags(flags), .ctl(ctl)
  );

  evt_flags_dp i_dp (
    .clk(clk), .rstN(rstN), .setVec(setVec), .ctl(ctl),
    .evtIrqEn(evtIrqEn), .bufIrqEn(bufIrqEn),
    .flags(flags), .evtIrq(evtIrq), .bufIrq(bufIrq)
  );

  assign flagStart    = flags[F_START];
  assign flagAddr     = flags[F_ADDR];
  assign flagHdr10    = flags[F_HDR];
  assign flagRxFull   = flags[F_RX];
  assign flagXferDone = flags[F_XFER];

  AST_START_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagStart) |-> $past(busWr && busAddr == DATA_ADDR)); // R1
  AST_ADDR_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagAddr) |-> $past(busRd && busAddr == STS3_ADDR)); // R2
  AST_HDR_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagHdr10) |-> $past(busWr && busAddr == DATA_ADDR)); // R3
  AST_RX_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagRxFull) |-> $past(busRd && busAddr == DATA_ADDR)); // R4
  AST_XFER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagXferDone) |-> $past(busRd && busAddr == DATA_ADDR)); // R5
endmodule

// File: tb/test_evt_status_flags.sv
module test_evt_status_flags;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setStart = 0, setAddr = 0, setHdr10 = 0, setRxFull = 0, setXferDone = 0;
  logic busRd = 0, busWr = 0;
  logic [3:0] busAddr = '0;
  logic evtIrqEn = 0, bufIrqEn = 0;
  logic flagStart, flagAddr, flagHdr10, flagRxFull, flagXferDone, evtIrq, bufIrq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference state: index 0 start, 1 addr, 2 hdr, 3 rx, 4 xfer
  bit refFlag[5];
  bit refArm[5];

  always #10 clk = ~clk; // 50 MHz

  evt_status_flags i_evt_status_flags (
    .clk(clk), .rstN(rstN),
    .setStart(setStart), .setAddr(setAddr), .setHdr10(setHdr10),
    .setRxFull(setRxFull), .setXferDone(setXferDone),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .evtIrqEn(evtIrqEn), .bufIrqEn(bufIrqEn),
    .flagStart(flagStart), .flagAddr(flagAddr), .flagHdr10(flagHdr10),
    .flagRxFull(flagRxFull), .flagXferDone(flagXferDone),
    .evtIrq(evtIrq), .bufIrq(bufIrq)
  );

  task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [6:0] dutVec();
    return {bufIrq, evtIrq, flagXferDone, flagRxFull, flagHdr10, flagAddr, flagStart};
  endfunction

  function automatic logic [6:0] refVec();
    logic e, b;
    e = evtIrqEn && (refFlag[0] || refFlag[1] || refFlag[2] || refFlag[4]);
    b = evtIrqEn && bufIrqEn && refFlag[3];
    return {b, e, refFlag[4], refFlag[3], refFlag[2], refFlag[1], refFlag[0]};
  endfunction

  task automatic modelEdge(input logic [4:0] s, input bit r, input bit w, input int a);
    bit nf[5];
    bit na[5];
    bit acc, completes;
    acc = r || w;
    for (int i = 0; i < 5; i++) begin
      case (i)
        0, 2: completes = w && a == 6;
        1:    completes = r && a == 9;
        4:    completes = r && a == 6;
        default: completes = 0;
      endcase
      if (i == 3) begin
        nf[i] = s[i] || (refFlag[i] && !(r && a == 6));
        na[i] = 0;
      end else begin
        nf[i] = s[i] || (refFlag[i] && !(refArm[i] && completes));
        na[i] = acc ? (r && a == 7 && refFlag[i]) : refArm[i];
      end
    end
    refFlag = nf;
    refArm = na;
  endtask

  // one clock cycle: drive at negedge, compare after the edge, return at negedge
  task automatic step(input logic [4:0] s, input bit r, input bit w, input int a);
    {setXferDone, setRxFull, setHdr10, setAddr, setStart} = s;
    busRd = r; busWr = w; busAddr = 4'(a);
    @(posedge clk);
    modelEdge(s, r, w, a);
    #5;
    chk("R12 model", dutVec(), refVec());
    @(negedge clk);
    {setXferDone, setRxFull, setHdr10, setAddr, setStart} = '0;
    busRd = 0; busWr = 0; busAddr = '0;
  endtask

  task automatic idle();
    step(5'b0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset", dutVec(), 7'b0);
    rstN = 1;
    idle();
    chk("R11 after reset", dutVec(), 7'b0);

    // R1: status read then data write
    step(5'b00001, 0, 0, 0);
    step(5'b0, 1, 0, 7);
    chk("R1 armed not yet cleared", {6'b0, flagStart}, 7'd1);
    step(5'b0, 0, 1, 6);
    chk("R1 cleared", {6'b0, flagStart}, 7'd0);

    // R2 with idle gap (R7 idle keeps arm)
    step(5'b00010, 0, 0, 0);
    step(5'b0, 1, 0, 7);
    idle(); idle();
    step(5'b0, 1, 0, 9);
    chk("R2 R7 cleared after idle gap", {6'b0, flagAddr}, 7'd0);

    // R3
    step(5'b00100, 0, 0, 0);
    step(5'b0, 1, 0, 7);
    step(5'b0, 0, 1, 6);
    chk("R3 cleared", {6'b0, flagHdr10}, 7'd0);

    // R4: single data read
    step(5'b01000, 0, 0, 0);
    chk("R4 set", {6'b0, flagRxFull}, 7'd1);
    step(5'b0, 1, 0, 6);
    chk("R4 cleared", {6'b0, flagRxFull}, 7'd0);

    // R5
    step(5'b10000, 0, 0, 0);
    step(5'b0, 1, 0, 7);
    step(5'b0, 1, 0, 6);
    chk("R5 cleared", {6'b0, flagXferDone}, 7'd0);

    // R6: second step alone does nothing
    step(5'b00001, 0, 0, 0);
    step(5'b0, 0, 1, 6);
    chk("R6 no first step", {6'b0, flagStart}, 7'd1);
    // R7: intervening access cancels
    step(5'b0, 1, 0, 7);
    step(5'b0, 1, 0, 9);
    step(5'b0, 0, 1, 6);
    chk("R7 cancelled by other access", {6'b0, flagStart}, 7'd1);
    step(5'b0, 1, 0, 7);
    step(5'b0, 0, 1, 6);
    chk("R1 cleared after retry", {6'b0, flagStart}, 7'd0);

    // R6: status read before flag set does not arm
    step(5'b0, 1, 0, 7);
    step(5'b00010, 0, 0, 0);
    step(5'b0, 1, 0, 9);
    chk("R6 early read ignored", {6'b0, flagAddr}, 7'd1);
    step(5'b0, 1, 0, 7);
    step(5'b0, 1, 0, 9);
    chk("R2 cleared", {6'b0, flagAddr}, 7'd0);

    // R8: set beats clear
    step(5'b00001, 0, 0, 0);
    step(5'b0, 1, 0, 7);
    step(5'b00001, 0, 1, 6);
    chk("R8 start set wins", {6'b0, flagStart}, 7'd1);
    step(5'b01000, 0, 0, 0);
    step(5'b01000, 1, 0, 6);
    chk("R8 rx set wins", {6'b0, flagRxFull}, 7'd1);

    // R9/R10: interrupts
    #1;
    chk("R9 disabled", {5'b0, bufIrq, evtIrq}, 7'b0);
    evtIrqEn = 1; #1;
    chk("R9 enabled", {6'b0, evtIrq}, 7'd1);
    chk("R10 buffer enable low", {6'b0, bufIrq}, 7'd0);
    bufIrqEn = 1; #1;
    chk("R10 buffer enabled", {6'b0, bufIrq}, 7'd1);
    @(negedge clk);
    step(5'b0, 1, 0, 7);
    step(5'b0, 0, 1, 6);
    chk("R9 no event flag left", {6'b0, evtIrq}, 7'd0);
    chk("R10 rx still pending", {6'b0, bufIrq}, 7'd1);
    step(5'b0, 1, 0, 6);
    chk("R10 cleared with rx", {6'b0, bufIrq}, 7'd0);
    step(5'b10100, 0, 0, 0);
    chk("R9 two events", {6'b0, evtIrq}, 7'd1);
    evtIrqEn = 0;
    idle();
    chk("R9 gated off", {6'b0, evtIrq}, 7'd0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule